// File: doc/BRIEF.md
# Device Address Translation Cache

This block is a small, fully associative store on the device side. It keeps translations that a host-side translation agent has returned, so that the device's DMA engines can turn an untranslated page number into a translated one without a round trip to the host. Each entry covers a naturally aligned range of 2^S pages of 4 KiB. It also holds six protection bits and an optional process-address-space tag.

Three things can arrive in any cycle, each with a single-cycle valid and no backpressure. A translation result fills an entry unless it reports failure. A lookup asks for one page, gives an access kind and may give a tag. An invalidation names an untranslated range, may give a tag, and carries a requester ID and an ITag. A lookup is answered one cycle later with hit, permission fault or miss, together with the translated page and the stored protection bits. An invalidation clears every matching entry at the clock edge that accepts it. Its completion record appears in the next cycle and echoes the requester ID and the ITag.

Top module: `atc_cache`

## Requirements
- R1: After reset no entry is valid: every lookup misses, and neither `rsp_valid` nor `cpl_valid` is asserted until a lookup or an invalidation is presented.
- R2: A lookup presented in cycle t is answered in cycle t+1 (`rsp_valid`=1). On a hit, `rsp_page` equals the stored translated base plus the page's offset from the entry's untranslated base, and `rsp_perm` equals the stored bits. A lookup sees the state as it stood before any fill or invalidation accepted in the same cycle.
- R3: A fill with `fill_ok`=0 (translation failed, no data) creates or changes no entry.
- R4: A successful fill goes to the lowest-numbered invalid entry. When all 8 entries are valid it replaces the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such a replacement. The pointer and the free-entry choice use the valid state from before a same-cycle invalidation.
- R5: An entry with size field S (0..15) covers 2^S pages starting at the fill page rounded down to a multiple of 2^S. The translated base is rounded down in the same way. A lookup anywhere inside that range hits, and a lookup outside it does not.
- R6: `lk_access` codes are 0 read, 1 write and 2 execute. Code 3 is never permitted. The protection bits are bit0 R, bit1 W, bit2 U, bit3 Exe, bit4 Priv and bit5 Global. If the matching entry lacks R, W or Exe for the requested access, the answer is `rsp_fault`=1 and `rsp_hit`=0, with `rsp_perm` giving the stored bits and `rsp_page`=0. On a miss, page and perm are 0.
- R7: An entry filled with a tag matches a lookup only if that lookup carries the same tag. An entry filled without a tag matches only lookups without a tag.
- R8: When several valid entries match a lookup, the entry written most recently supplies the answer.
- R9: An invalidation clears every valid entry whose range overlaps the invalidated range: 2^S pages from `inv_page` rounded down to a multiple of 2^S. An invalidation with a tag clears only entries holding the same tag. One without a tag ignores tags. A lookup presented in the next cycle already sees the entries cleared.
- R10: An invalidation accepted in cycle t produces exactly one completion in cycle t+1, with `cpl_rid` and `cpl_itag` equal to the request's `inv_rid` and `inv_itag`.
- R11: When a successful fill and an invalidation are accepted in the same cycle, the invalidation is applied first and the filled entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fill_valid | input | 1 | A translation result is present |
| fill_ok | input | 1 | 1 = result carries data; 0 = translation failed |
| fill_page | input | 36 | Untranslated page number |
| fill_xlat | input | 36 | Translated page number |
| fill_lsize | input | 4 | Log2 of the page count covered |
| fill_perm | input | 6 | Protection bits {Global, Priv, Exe, U, W, R} |
| fill_pv | input | 1 | A tag is present on the fill |
| fill_pasid | input | 20 | Process-address-space tag |
| lk_valid | input | 1 | A lookup is present |
| lk_page | input | 36 | Page to translate |
| lk_access | input | 2 | 0 read, 1 write, 2 execute |
| lk_pv | input | 1 | A tag is present on the lookup |
| lk_pasid | input | 20 | Lookup tag |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_fault | output | 1 | Translation found but access refused |
| rsp_page | output | 36 | Translated page |
| rsp_perm | output | 6 | Stored protection bits |
| inv_valid | input | 1 | An invalidation is present |
| inv_page | input | 36 | Start of the invalidated range |
| inv_lsize | input | 4 | Log2 of the invalidated page count |
| inv_pv | input | 1 | A tag is present on the invalidation |
| inv_pasid | input | 20 | Invalidation tag |
| inv_rid | input | 16 | Requester ID to echo |
| inv_itag | input | 5 | ITag to echo |
| cpl_valid | output | 1 | Invalidation completion present |
| cpl_rid | output | 16 | Echoed requester ID |
| cpl_itag | output | 5 | Echoed ITag |

## Verification
A stale valid bit shows at the ports as a hit, or as a fault that should have been a miss, on the first lookup of that range. The answer appears one cycle after the lookup. A wrong recency order shows only when two live entries overlap, as a wrong `rsp_page`. A wrong round-robin pointer shows as a miss on an entry that should have survived, seen on a later lookup. These are not immediate symptoms, so the stimulus fills past capacity, builds overlapping entries and looks up right after each invalidation. A reference model checks every cycle.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int PAGE_W  = 36;
  localparam int SIZE_W  = 4;
  localparam int PASID_W = 20;
  localparam int RID_W   = 16;
  localparam int ITAG_W  = 5;
  localparam int PERM_N  = 6;

  localparam int P_R    = 0;
  localparam int P_WR   = 1;
  localparam int P_U    = 2;
  localparam int P_X    = 3;
  localparam int P_PRIV = 4;
  localparam int P_G    = 5;

  typedef logic [PAGE_W-1:0] page_t;

  typedef struct packed {
    page_t               base;
    page_t               xlat;
    logic [SIZE_W-1:0]   lsize;
    logic [PERM_N-1:0]   perm;
    logic                pv;
    logic [PASID_W-1:0]  pasid;
  } entry_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } access_e;

  function automatic page_t span_mask(input logic [SIZE_W-1:0] s);
    return {PAGE_W{1'b1}} << s;
  endfunction
endpackage

// File: rtl/atc_match.sv
module atc_match
  import atc_pkg::*;
#(
  parameter int N = 8
) (
  input  entry_t [N-1:0]     ent,
  input  logic   [N-1:0]     valid,
  input  page_t              lk_page,
  input  logic               lk_pv,
  input  logic [PASID_W-1:0] lk_pasid,
  input  page_t              inv_page,
  input  logic [SIZE_W-1:0]  inv_lsize,
  input  logic               inv_pv,
  input  logic [PASID_W-1:0] inv_pasid,
  output logic [N-1:0]       lk_hits,
  output logic [N-1:0]       inv_hits
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    page_t             emask;
    page_t             omask;
    logic [SIZE_W-1:0] wider;
    logic              tag_lk;
    logic              tag_inv;

    assign emask   = span_mask(ent[i].lsize);
    assign wider   = (ent[i].lsize > inv_lsize) ? ent[i].lsize : inv_lsize;
    assign omask   = span_mask(wider);
    assign tag_lk  = (ent[i].pv == lk_pv) && (!lk_pv || (ent[i].pasid == lk_pasid));
    assign tag_inv = !inv_pv || (ent[i].pv && (ent[i].pasid == inv_pasid));

    assign lk_hits[i]  = valid[i] && tag_lk &&
                         (((lk_page ^ ent[i].base) & emask) == '0);
    assign inv_hits[i] = valid[i] && tag_inv &&
                         (((inv_page ^ ent[i].base) & omask) == '0);
  end
endmodule

// File: rtl/atc_recency.sv
module atc_recency #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] widx,
  input  logic [N-1:0] hits,
  output logic [N-1:0] win
);
  // newer_q[i][j] = 1 : entry i was written after entry j
  logic [N-1:0][N-1:0] newer_q;
  logic [N-1:0][N-1:0] newer_d;

  always_comb begin
    newer_d = newer_q;
    if (we) begin
      for (int i = 0; i < N; i++) begin
        if (widx[i]) newer_d[i] = ~widx;
        else         newer_d[i] = newer_q[i] & ~widx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  newer_q <= '0;
    else if (we) newer_q <= newer_d;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (hits[j] && newer_q[j][i]) beaten = 1'b1;
      end
      win[i] = hits[i] && !beaten;
    end
  end

  assert_single_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits) |-> $onehot(win));
endmodule

// File: rtl/atc_victim.sv
module atc_victim #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] valid,
  input  logic         take,
  output logic [N-1:0] sel
);
  localparam int RR_W = (N > 1) ? $clog2(N) : 1;

  logic [RR_W-1:0] rr_q;
  logic [RR_W-1:0] rr_d;
  logic            full;

  assign full = &valid;

  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && !valid[i]) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    if (full) sel = N'(1) << rr_q;
  end

  always_comb begin
    rr_d = rr_q;
    if (take && full) rr_d = (rr_q == RR_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  assert_rr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full) |=> $stable(rr_q));
  assert_free_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !full) |-> ((sel & valid) == '0) && $onehot(sel));
endmodule

// File: rtl/atc_cache.sv
module atc_cache
  import atc_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_valid,
  input  logic               fill_ok,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [PAGE_W-1:0]  fill_xlat,
  input  logic [SIZE_W-1:0]  fill_lsize,
  input  logic [PERM_N-1:0]  fill_perm,
  input  logic               fill_pv,
  input  logic [PASID_W-1:0] fill_pasid,
  input  logic               lk_valid,
  input  logic [PAGE_W-1:0]  lk_page,
  input  logic [1:0]         lk_access,
  input  logic               lk_pv,
  input  logic [PASID_W-1:0] lk_pasid,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic [PAGE_W-1:0]  rsp_page,
  output logic [PERM_N-1:0]  rsp_perm,
  input  logic               inv_valid,
  input  logic [PAGE_W-1:0]  inv_page,
  input  logic [SIZE_W-1:0]  inv_lsize,
  input  logic               inv_pv,
  input  logic [PASID_W-1:0] inv_pasid,
  input  logic [RID_W-1:0]   inv_rid,
  input  logic [ITAG_W-1:0]  inv_itag,
  output logic               cpl_valid,
  output logic [RID_W-1:0]   cpl_rid,
  output logic [ITAG_W-1:0]  cpl_itag
);
  localparam int N = N_ENTRIES;

  entry_t [N-1:0] ent_q;
  logic   [N-1:0] valid_q;
  logic   [N-1:0] valid_d;
  logic   [N-1:0] lk_hits;
  logic   [N-1:0] inv_hits;
  logic   [N-1:0] win;
  logic   [N-1:0] vsel;
  logic           fill_we;
  entry_t         new_ent;
  page_t          fmask;

  // ---------------- fill path ----------------
  assign fill_we = fill_valid && fill_ok;
  assign fmask   = span_mask(fill_lsize);

  always_comb begin
    new_ent.base  = fill_page & fmask;
    new_ent.xlat  = fill_xlat & fmask;
    new_ent.lsize = fill_lsize;
    new_ent.perm  = fill_perm;
    new_ent.pv    = fill_pv;
    new_ent.pasid = fill_pasid;
  end

  atc_victim #(.N(N)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (valid_q),
    .take  (fill_we),
    .sel   (vsel)
  );

  atc_match #(.N(N)) u_match (
    .ent       (ent_q),
    .valid     (valid_q),
    .lk_page   (lk_page),
    .lk_pv     (lk_pv),
    .lk_pasid  (lk_pasid),
    .inv_page  (inv_page),
    .inv_lsize (inv_lsize),
    .inv_pv    (inv_pv),
    .inv_pasid (inv_pasid),
    .lk_hits   (lk_hits),
    .inv_hits  (inv_hits)
  );

  atc_recency #(.N(N)) u_recency (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fill_we),
    .widx  (vsel),
    .hits  (lk_hits),
    .win   (win)
  );

  // invalidation clears first, a same-cycle fill then lands
  always_comb begin
    valid_d = valid_q;
    if (inv_valid) valid_d = valid_d & ~inv_hits;
    if (fill_we)   valid_d = valid_d | vsel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (fill_we && vsel[i]) ent_q[i] <= new_ent;
    end
  end

  // ---------------- lookup path ----------------
  entry_t             wsel;
  logic               any_win;
  logic               allowed;
  page_t              wmask;
  logic               rsp_hit_d;
  logic               rsp_fault_d;
  page_t              rsp_page_d;
  logic [PERM_N-1:0]  rsp_perm_d;

  always_comb begin
    wsel = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) wsel = entry_t'(wsel | ent_q[i]);
    end
  end

  assign any_win = |win;
  assign wmask   = span_mask(wsel.lsize);

  always_comb begin
    unique case (access_e'(lk_access))
      ACC_READ:  allowed = wsel.perm[P_R];
      ACC_WRITE: allowed = wsel.perm[P_WR];
      ACC_EXEC:  allowed = wsel.perm[P_X];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    rsp_hit_d   = 1'b0;
    rsp_fault_d = 1'b0;
    rsp_page_d  = '0;
    rsp_perm_d  = '0;
    if (lk_valid && any_win) begin
      rsp_perm_d = wsel.perm;
      if (allowed) begin
        rsp_hit_d  = 1'b1;
        rsp_page_d = (wsel.xlat & wmask) | (lk_page & ~wmask);
      end else begin
        rsp_fault_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_page  <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= rsp_hit_d;
      rsp_fault <= rsp_fault_d;
      rsp_page  <= rsp_page_d;
      rsp_perm  <= rsp_perm_d;
    end
  end

  // ---------------- invalidation completion ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_valid <= 1'b0;
      cpl_rid   <= '0;
      cpl_itag  <= '0;
    end else begin
      cpl_valid <= inv_valid;
      if (inv_valid) begin
        cpl_rid  <= inv_rid;
        cpl_itag <= inv_itag;
      end
    end
  end

  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_failed_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ok && !inv_valid) |=> (valid_q == $past(valid_q)));
  assert_read_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && ($past(lk_access) == 2'd0)) |-> rsp_perm[P_R]);
  assert_inv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_valid) |=> ((valid_q & $past(inv_hits)) == '0));
  assert_cpl_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> (cpl_valid && cpl_rid == $past(inv_rid) && cpl_itag == $past(inv_itag)));
  assert_fill_survives_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && inv_valid) |=> ((valid_q & $past(vsel)) == $past(vsel)));
endmodule

// File: tb/atc_cache_test.sv
module atc_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_valid = 0, fill_ok = 0, fill_pv = 0;
  logic [35:0] fill_page = 0, fill_xlat = 0;
  logic [3:0]  fill_lsize = 0;
  logic [5:0]  fill_perm = 0;
  logic [19:0] fill_pasid = 0;
  logic        lk_valid = 0, lk_pv = 0;
  logic [35:0] lk_page = 0;
  logic [1:0]  lk_access = 0;
  logic [19:0] lk_pasid = 0;
  logic        inv_valid = 0, inv_pv = 0;
  logic [35:0] inv_page = 0;
  logic [3:0]  inv_lsize = 0;
  logic [19:0] inv_pasid = 0;
  logic [15:0] inv_rid = 0;
  logic [4:0]  inv_itag = 0;
  logic        rsp_valid, rsp_hit, rsp_fault, cpl_valid;
  logic [35:0] rsp_page;
  logic [5:0]  rsp_perm;
  logic [15:0] cpl_rid;
  logic [4:0]  cpl_itag;

  atc_cache uut (.*);

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_v[8];
  longint      m_base[8], m_xlat[8], m_stamp[8];
  int          m_ls[8];
  bit [5:0]    m_perm[8];
  bit          m_pv[8];
  int          m_pasid[8];
  longint      stamp = 0;
  int          m_rr = 0;
  bit          e_rv, e_hit, e_fault, e_cv;
  longint      e_page;
  bit [5:0]    e_perm;
  int          e_rid, e_itag;

  function automatic longint span(input int ls); return longint'(1) << ls; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_v[i] = 0;
      m_rr = 0; e_rv = 0; e_hit = 0; e_fault = 0; e_cv = 0; e_page = 0; e_perm = 0;
    end else begin
      int best; int victim; bit fullv; bit ok;
      longint ilo, ihi, flo;
      // lookup answer from pre-update state
      best = -1;
      if (lk_valid) begin
        for (int i = 0; i < 8; i++) begin
          if (m_v[i] && longint'(lk_page) >= m_base[i] &&
              longint'(lk_page) < m_base[i] + span(m_ls[i]) &&
              m_pv[i] == lk_pv && (!lk_pv || m_pasid[i] == int'(lk_pasid)))
            if (best < 0 || m_stamp[i] > m_stamp[best]) best = i;
        end
      end
      e_rv = lk_valid; e_hit = 0; e_fault = 0; e_page = 0; e_perm = 0;
      if (best >= 0) begin
        ok = (lk_access == 0) ? m_perm[best][0] :
             (lk_access == 1) ? m_perm[best][1] :
             (lk_access == 2) ? m_perm[best][3] : 1'b0;
        e_perm = m_perm[best];
        if (ok) begin e_hit = 1; e_page = m_xlat[best] + (longint'(lk_page) - m_base[best]); end
        else e_fault = 1;
      end
      e_cv = inv_valid;
      if (inv_valid) begin e_rid = inv_rid; e_itag = inv_itag; end
      // victim from pre-update valid state
      victim = -1; fullv = 1;
      for (int i = 0; i < 8; i++) if (!m_v[i]) begin fullv = 0; if (victim < 0) victim = i; end
      if (fullv) victim = m_rr;
      if (inv_valid) begin
        ilo = longint'(inv_page) / span(inv_lsize) * span(inv_lsize);
        ihi = ilo + span(inv_lsize) - 1;
        for (int i = 0; i < 8; i++)
          if (m_v[i] && m_base[i] <= ihi && ilo <= m_base[i] + span(m_ls[i]) - 1 &&
              (!inv_pv || (m_pv[i] && m_pasid[i] == int'(inv_pasid))))
            m_v[i] = 0;
      end
      if (fill_valid && fill_ok) begin
        if (fullv) m_rr = (m_rr + 1) % 8;
        flo = longint'(fill_page) / span(fill_lsize) * span(fill_lsize);
        m_v[victim] = 1; m_base[victim] = flo;
        m_xlat[victim] = longint'(fill_xlat) / span(fill_lsize) * span(fill_lsize);
        m_ls[victim] = fill_lsize; m_perm[victim] = fill_perm;
        m_pv[victim] = fill_pv; m_pasid[victim] = fill_pasid;
        stamp++; m_stamp[victim] = stamp;
      end
    end
  end

  // compare away from the active edge
  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(rsp_valid == e_rv && rsp_hit == e_hit && rsp_fault == e_fault &&
          longint'(rsp_page) == e_page && rsp_perm == e_perm, tag, "lookup answer",
          {rsp_valid, rsp_hit, rsp_fault, rsp_perm, rsp_page},
          {e_rv, e_hit, e_fault, e_perm, e_page[35:0]});
      chk(cpl_valid == e_cv && (!e_cv || (int'(cpl_rid) == e_rid && int'(cpl_itag) == e_itag)),
          (e_cv ? "R10" : tag), "completion", {cpl_valid, cpl_rid, cpl_itag},
          {e_cv, e_rid[15:0], e_itag[4:0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_fill(input longint pg, input longint xl, input int ls,
                          input bit [5:0] pm, input bit ok, input bit pv, input int ps);
    fill_valid = 1; fill_ok = ok; fill_page = pg[35:0]; fill_xlat = xl[35:0];
    fill_lsize = ls[3:0]; fill_perm = pm; fill_pv = pv; fill_pasid = ps[19:0];
  endtask
  task automatic set_lk(input longint pg, input int acc, input bit pv, input int ps);
    lk_valid = 1; lk_page = pg[35:0]; lk_access = acc[1:0]; lk_pv = pv; lk_pasid = ps[19:0];
  endtask
  task automatic set_inv(input longint pg, input int ls, input bit pv, input int ps,
                         input int rid, input int it);
    inv_valid = 1; inv_page = pg[35:0]; inv_lsize = ls[3:0]; inv_pv = pv;
    inv_pasid = ps[19:0]; inv_rid = rid[15:0]; inv_itag = it[4:0];
  endtask
  task automatic tick();
    @(negedge clk);
    fill_valid = 0; lk_valid = 0; inv_valid = 0;
  endtask
  task automatic lk1(input longint pg, input int acc, input bit pv, input int ps);
    set_lk(pg, acc, pv, ps); tick(); tick();
  endtask

  initial begin
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    chk(0, "ALL", "watchdog expired", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid && !cpl_valid, "R1", "outputs idle after reset", {rsp_valid, cpl_valid}, 0);
    cmp_en = 1;
    tag = "R1"; lk1(36'h100, 0, 0, 0);
    tag = "R2"; set_fill(36'h100, 36'h900, 0, 6'b000011, 1, 0, 0); tick();
    lk1(36'h100, 0, 0, 0); lk1(36'h100, 1, 0, 0);
    tag = "R5"; set_fill(36'h203, 36'hA07, 2, 6'b001001, 1, 0, 0); tick();
    lk1(36'h200, 0, 0, 0); lk1(36'h203, 2, 0, 0); lk1(36'h204, 0, 0, 0); lk1(36'h1FF, 0, 0, 0);
    tag = "R6"; lk1(36'h100, 2, 0, 0); lk1(36'h202, 1, 0, 0); lk1(36'h201, 3, 0, 0);
    tag = "R7"; set_fill(36'h300, 36'hB00, 0, 6'b111111, 1, 1, 5); tick();
    lk1(36'h300, 0, 1, 5); lk1(36'h300, 0, 1, 6); lk1(36'h300, 0, 0, 0); lk1(36'h100, 0, 1, 5);
    tag = "R3"; set_fill(36'h400, 36'hC00, 0, 6'b000001, 0, 0, 0); tick(); lk1(36'h400, 0, 0, 0);
    tag = "R8"; set_fill(36'h500, 36'h110, 0, 6'b000001, 1, 0, 0); tick();
    set_fill(36'h500, 36'h220, 1, 6'b000011, 1, 0, 0); tick();
    lk1(36'h500, 0, 0, 0); lk1(36'h501, 1, 0, 0);
    set_fill(36'h500, 36'h330, 0, 6'b000001, 1, 0, 0); set_lk(36'h500, 0, 0, 0); tick();
    lk1(36'h500, 0, 0, 0);
    tag = "R9"; set_inv(36'h504, 3, 0, 0, 16'hBEEF, 7); tick();
    set_lk(36'h500, 0, 0, 0); tick(); lk1(36'h501, 0, 0, 0);
    set_inv(36'h300, 0, 1, 6, 16'h1234, 9); tick(); lk1(36'h300, 0, 1, 5);
    set_inv(36'h300, 0, 1, 5, 16'h1235, 10); tick(); lk1(36'h300, 0, 1, 5);
    set_inv(36'h100, 0, 0, 0, 16'h0001, 31); set_lk(36'h100, 0, 0, 0); tick(); lk1(36'h100, 0, 0, 0);
    tag = "R11"; set_fill(36'h600, 36'hD00, 0, 6'b000001, 1, 0, 0);
    set_inv(36'h600, 0, 0, 0, 16'h0600, 3); tick(); lk1(36'h600, 0, 0, 0);
    tag = "R4";
    for (int i = 0; i < 12; i++) begin
      set_fill(36'h1000 + i, 36'h8000 + i, 0, 6'b000001, 1, 0, 0); tick();
    end
    for (int i = 0; i < 12; i++) lk1(36'h1000 + i, 0, 0, 0);
    lk1(36'h203, 0, 0, 0);
    tag = "R2";
    for (int n = 0; n < 400; n++) begin
      int r; r = $urandom % 8;
      if (r < 3) set_fill($urandom % 64, 36'h40000 + ($urandom % 4096), $urandom % 4,
                          6'($urandom), ($urandom % 4) != 0, $urandom % 2, $urandom % 2);
      if (r >= 2) set_lk($urandom % 64, $urandom % 4, $urandom % 2, $urandom % 2);
      if (r == 7 || r == 2) set_inv($urandom % 64, $urandom % 4, $urandom % 2, $urandom % 2,
                                    $urandom % 65536, $urandom % 32);
      tick();
    end
    tick(); tick();
    cmp_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule